// File: doc/BRIEF.md
# UART Interrupt Mask and Status Controller

This block handles interrupt bookkeeping for one UART channel. Software never loads the interrupt mask directly. It turns sources on by writing ones to a set-only enable port and turns them off by writing ones to a clear-only disable port. The resulting mask can be read at its own address.

Single-cycle event pulses from the UART core land in a sticky status register, but only for sources whose mask bit is set. Software acknowledges a source by writing a one to its status bit. A registered interrupt line is raised whenever an enabled source is pending.

A separate channel-status view shows the live receive and transmit level conditions straight from the core, whatever the mask holds. The bus side is a plain read and write strobe with an address. Reads are combinational.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask, the status register and `irq_o` are all zero.
- R2: A write to offset 0x08 sets each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value. The new mask is readable after the clock edge that takes the write.
- R3: A write to offset 0x0C clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R4: Reads of offsets 0x08 and 0x0C always return zero.
- R5: The mask at offset 0x10 changes only through offsets 0x08 and 0x0C, so a write to 0x10 has no effect. The status register at offset 0x14 cannot be loaded with ones by a write.
- R6: An event pulse on bit n of `event_i` sets status bit n only if mask bit n is set. Bit meanings are: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 overrun, 6 framing error, 7 parity error, 8 receive timeout. Bits 9 to 12 are spare.
- R7: Writing 1 to a status bit at offset 0x14 clears that bit, and writing 0 leaves it unchanged. An enabled event arriving on the same clock edge as the clear wins, and the bit stays set.
- R8: `irq_o` equals, one clock later, the OR over all bits of (status AND mask). Clearing a mask bit drops the interrupt while the status bit stays set. Setting the mask bit again raises the interrupt.
- R9: A read of offset 0x2C returns bits 0, 1, 3 and 4 of `cond_i` live, whatever the mask holds. All other bits read zero.
- R10: Reads with `rd_en_i` low, reads of unmapped offsets, and all bits above bit 12 of `rdata_o` return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe; `rdata_o` is valid in the same cycle |
| addr_i | input | ADDR_W (8) | Byte offset of the access |
| wdata_i | input | IRQ_W (13) | Write data |
| rdata_o | output | DATA_W (32) | Read data, zero-extended |
| event_i | input | IRQ_W (13) | One-cycle event pulses from the UART core |
| cond_i | input | IRQ_W (13) | Live level conditions from the UART core |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench checks that a zero in the enable or disable data leaves the matching mask bit alone. A design that wrote the mask directly would wipe out the sources software had already enabled.

It sends an event on the same edge as a write-one-to-clear of that status bit, expecting the bit to survive. A design where the clear won would lose an event that software never saw.

It turns a pending source off through the disable port and expects the interrupt to drop while the status bit stays set. A design that gated only the status input, or cleared status along with the mask, would either keep interrupting or forget the event.

It also checks the one-cycle interrupt latency and that masked-off events leave no trace. Finally, it checks that the channel-status view ignores the mask and shows only its four live bits.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IRQ_W  = 13;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  // source bit positions
  localparam int B_RX_TRIG  = 0;
  localparam int B_RX_EMPTY = 1;
  localparam int B_RX_FULL  = 2;
  localparam int B_TX_EMPTY = 3;
  localparam int B_TX_FULL  = 4;
  localparam int B_OVERRUN  = 5;
  localparam int B_FRAMING  = 6;
  localparam int B_PARITY   = 7;
  localparam int B_RX_TOUT  = 8;

  localparam logic [IRQ_W-1:0] CHAN_VIEW =
    IRQ_W'((1 << B_RX_TRIG) | (1 << B_RX_EMPTY) | (1 << B_TX_EMPTY) | (1 << B_TX_FULL));

  localparam logic [7:0] OFF_EN   = 8'h08;
  localparam logic [7:0] OFF_DIS  = 8'h0C;
  localparam logic [7:0] OFF_MASK = 8'h10;
  localparam logic [7:0] OFF_STS  = 8'h14;
  localparam logic [7:0] OFF_CHAN = 8'h2C;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else         mask_o <= (mask_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     status_o[b] <= 1'b0;
      else if (evt_i[b] && mask_i[b])  status_o[b] <= 1'b1;  // set beats clear
      else if (clr_i[b])               status_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(status_i & mask_i);
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int IRQ_W  = uart_irq_pkg::IRQ_W,
  parameter int DATA_W = uart_irq_pkg::DATA_W,
  parameter int ADDR_W = uart_irq_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IRQ_W-1:0]  wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [IRQ_W-1:0]  event_i,
  input  logic [IRQ_W-1:0]  cond_i,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - IRQ_W;

  logic [IRQ_W-1:0] mask_q, status_q;
  logic [IRQ_W-1:0] set_d, clr_d, ack_d, rd_val;
  logic hit_en, hit_dis, hit_sts;

  assign hit_en  = wr_en_i && (addr_i == ADDR_W'(OFF_EN));
  assign hit_dis = wr_en_i && (addr_i == ADDR_W'(OFF_DIS));
  assign hit_sts = wr_en_i && (addr_i == ADDR_W'(OFF_STS));

  assign set_d = hit_en  ? wdata_i : '0;
  assign clr_d = hit_dis ? wdata_i : '0;
  assign ack_d = hit_sts ? wdata_i : '0;

  irq_mask_reg #(.W(IRQ_W)) u_mask (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (set_d), .clr_i (clr_d), .mask_o (mask_q)
  );

  irq_status_reg #(.W(IRQ_W)) u_status (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .evt_i (event_i), .mask_i (mask_q), .clr_i (ack_d), .status_o (status_q)
  );

  irq_out_reg #(.W(IRQ_W)) u_irq (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .status_i (status_q), .mask_i (mask_q), .irq_o (irq_o)
  );

  // enable/disable ports and unmapped offsets read as zero
  always_comb begin
    rd_val = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        ADDR_W'(OFF_MASK): rd_val = mask_q;
        ADDR_W'(OFF_STS):  rd_val = status_q;
        ADDR_W'(OFF_CHAN): rd_val = cond_i & CHAN_VIEW;
        default:           rd_val = '0;
      endcase
    end
  end

  assign rdata_o = {{PAD_W{1'b0}}, rd_val};
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
  import uart_irq_pkg::*;
#(
  parameter int IRQ_W  = uart_irq_pkg::IRQ_W,
  parameter int ADDR_W = uart_irq_pkg::ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [IRQ_W-1:0]  wdata_i,
  input logic [IRQ_W-1:0]  event_i,
  input logic              irq_o,
  input logic [IRQ_W-1:0]  mask_q,
  input logic [IRQ_W-1:0]  status_q
);
  logic wr_en_hit, wr_dis_hit;
  assign wr_en_hit  = wr_en_i && (addr_i == ADDR_W'(OFF_EN));
  assign wr_dis_hit = wr_en_i && (addr_i == ADDR_W'(OFF_DIS));

  assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (mask_q == '0 && status_q == '0 && !irq_o));

  assert_enable_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_hit |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  assert_disable_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dis_hit |=> ((mask_q & $past(wdata_i)) == '0));

  assert_mask_only_via_ports_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_hit || wr_dis_hit) |=> $stable(mask_q));

  assert_masked_event_blocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(mask_q)) == '0));

  assert_set_beats_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(event_i & mask_q)) |=> ((status_q & $past(event_i & mask_q)) == $past(event_i & mask_q)));

  assert_irq_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(status_q & mask_q))));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.IRQ_W(IRQ_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .event_i  (event_i),
  .irq_o    (irq_o),
  .mask_q   (mask_q),
  .status_q (status_q)
);

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb;
  localparam int W = 13;

  localparam logic [7:0] A_EN   = 8'h08;
  localparam logic [7:0] A_DIS  = 8'h0C;
  localparam logic [7:0] A_MASK = 8'h10;
  localparam logic [7:0] A_STS  = 8'h14;
  localparam logic [7:0] A_CHAN = 8'h2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [W-1:0] wdata = '0, evt = '0, cond = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl u_dut (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .rd_en_i (rd_en),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata),
    .event_i (evt), .cond_i (cond), .irq_o (irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [W-1:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'd0, irq}, 32'd0);
    bus_rd(A_MASK, d); check("R1 mask", d, 32'h0);
    bus_rd(A_STS, d);  check("R1 status", d, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    bus_wr(A_EN, 13'h009);
    bus_rd(A_MASK, d); check("R2 first set", d, 32'h009);
    bus_wr(A_EN, 13'h100);
    bus_rd(A_MASK, d); check("R2 zeros keep bits", d, 32'h109);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    bus_wr(A_DIS, 13'h001);
    bus_rd(A_MASK, d); check("R3 clear one bit", d, 32'h108);
    bus_rd(A_EN, d);   check("R4 enable port reads zero", d, 32'h0);
    bus_rd(A_DIS, d);  check("R4 disable port reads zero", d, 32'h0);
  endtask

  task automatic t_no_direct();
    logic [31:0] d;
    bus_wr(A_MASK, 13'h1FFF);
    bus_rd(A_MASK, d); check("R5 mask not writable", d, 32'h108);
    bus_wr(A_STS, 13'h1FFF);
    bus_rd(A_STS, d);  check("R5 status not loadable", d, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse(13'h0C3);  // bits 0,1,6,7 all masked off
    bus_rd(A_STS, d); check("R6 masked events dropped", d, 32'h0);
    check("R6 no irq", {31'd0, irq}, 32'd0);
    pulse(13'h008);
    check("R8 irq not yet", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R8 irq one cycle later", {31'd0, irq}, 32'd1);
    bus_rd(A_STS, d); check("R6 enabled event latched", d, 32'h008);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    bus_wr(A_STS, 13'h008);
    check("R8 irq lags ack", {31'd0, irq}, 32'd1);
    @(negedge clk);
    check("R8 irq drops after ack", {31'd0, irq}, 32'd0);
    bus_rd(A_STS, d); check("R7 write-one clears", d, 32'h0);
    pulse(13'h100);
    @(negedge clk); wr_en = 1'b1; addr = A_STS; wdata = 13'h100; evt = 13'h100;
    @(negedge clk); wr_en = 1'b0; wdata = '0; evt = '0;
    bus_rd(A_STS, d); check("R7 set wins over clear", d, 32'h100);
    bus_wr(A_STS, 13'h0FF);
    bus_rd(A_STS, d); check("R7 zero bits keep status", d, 32'h100);
  endtask

  task automatic t_mask_gate();
    logic [31:0] d;
    check("R8 irq pending", {31'd0, irq}, 32'd1);
    bus_wr(A_DIS, 13'h100);
    @(negedge clk);
    check("R8 irq gated by mask", {31'd0, irq}, 32'd0);
    bus_rd(A_STS, d); check("R8 status stays sticky", d, 32'h100);
    bus_wr(A_EN, 13'h100);
    @(negedge clk);
    check("R8 irq returns on re-enable", {31'd0, irq}, 32'd1);
    bus_wr(A_STS, 13'h100);
  endtask

  task automatic t_chan();
    logic [31:0] d;
    cond = 13'h1FFF;
    bus_rd(A_CHAN, d); check("R9 live bits only", d, 32'h01B);
    cond = 13'h00A;
    bus_rd(A_CHAN, d); check("R9 partial", d, 32'h00A);
    cond = 13'h1E4;
    bus_rd(A_CHAN, d); check("R9 other bits hidden", d, 32'h0);
    cond = '0;
  endtask

  task automatic t_reads();
    logic [31:0] d;
    bus_rd(8'h04, d); check("R10 unmapped 0x04", d, 32'h0);
    bus_rd(8'h30, d); check("R10 unmapped 0x30", d, 32'h0);
    @(negedge clk); addr = A_MASK; rd_en = 1'b0;
    #1 check("R10 no strobe reads zero", rdata, 32'h0);
    bus_rd(A_MASK, d); check("R10 upper bits zero", d & 32'hFFFF_E000, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_disable();
    t_no_direct();
    t_events();
    t_ack();
    t_mask_gate();
    t_chan();
    t_reads();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule